// File: doc/BRIEF.md
# Two-Channel Serial ADC Read Controller

This block sits on the host side of a small serial analog-to-digital converter that offers two inputs. The converter has no address pins. A read of input 0 begins with one high-then-low pulse on the conversion-start line. A read of input 1 begins with two such pulses. The converter runs its own conversion clock, so the host only has to wait a fixed minimum time. After that wait, the host fetches the 8-bit answer with eight serial clock pulses. The converter's most significant bit is already on the data line when the conversion ends. The converter moves to each later bit on a falling serial clock edge.

A user asks for a reading by raising a request together with a channel bit. The controller holds busy, produces the start pulses and times the conversion wait. It then clocks out the eight bits and returns the assembled byte with a single-cycle done strobe. The start pulse width, the conversion wait and the serial clock half period are all derived from the system clock period, and each is rounded up to meet its minimum. A parameter sets whether the serial clock rests low or high, which covers both of the matching SPI modes (0,0 and 1,1).

Top module: `adc_reader`

## Requirements
- R1: After reset, busy, done, result and conv_start are all 0, and sclk rests at the SCLK_IDLE level.
- R2: A request with chan = 0 produces exactly one high pulse on conv_start. A request with chan = 1 produces exactly two.
- R3: Each conv_start high phase, and the low gap between the two pulses of a channel-1 read, lasts at least ceil(START_MIN_PS / CLK_PERIOD_PS) cycles. With the default parameters this is 7 cycles.
- R4: sclk does not change until at least ceil(CONV_MIN_PS / CLK_PERIOD_PS) cycles after the last falling edge of conv_start. With the default parameters this is 938 cycles.
- R5: Each read issues exactly eight sclk pulses, which is 16 level changes. Each level lasts at least ceil(SCLK_MIN_PERIOD_PS / (2 * CLK_PERIOD_PS)) cycles, which is 13 cycles by default. sclk returns to SCLK_IDLE afterwards.
- R6: result[7] is the din level seen just before the first sclk edge. Each lower bit, in order down to result[0], is din sampled at the next rising sclk edge that follows a falling sclk edge. The result is straight binary with the most significant bit first.
- R7: busy is 1 from the cycle after an accepted request until the done cycle. done is 1 for exactly one cycle per read, and busy is 0 in that cycle. result changes only together with done.
- R8: A request raised while busy is 1 is ignored. It adds no start pulses, it does not change the channel of the read in progress, and it does not cause a second done.
- R9: With SCLK_IDLE = 1, sclk rests high, still gives eight pulses and returns the same result as the low-idle setting.
- R10: A request present in the done cycle is accepted, so busy is 1 again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Read request, sampled while idle |
| chan | input | 1 | Channel to read (0 or 1), sampled with req |
| busy | output | 1 | A read is in progress |
| done | output | 1 | One-cycle strobe marking a new result |
| result | output | 8 | Converted value, held until the next done |
| conv_start | output | 1 | Conversion-start line to the converter |
| sclk | output | 1 | Serial clock to the converter |
| din | input | 1 | Serial data from the converter |

## Verification
The assertions take for granted that din is synchronous to the system clock. They also take for granted that din changes only after the falling sclk edges this block generates, and that it shows the most significant bit before the conversion wait ends. The bench's converter model meets both conditions. It updates din one system clock after it sees sclk fall, which is well inside the 13-cycle half period, and it puts the first bit out 38 cycles before the controller's wait expires. The assertions also expect chan to be valid in the cycle in which req is taken. The bench always drives the two together at a falling clock edge.

// File: rtl/adc_reader_pkg.sv
package adc_reader_pkg;

    localparam int unsigned RES_W        = 8;
    localparam int unsigned HALF_PERIODS = 2 * RES_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START_HI,
        ST_START_LO,
        ST_CONVERT,
        ST_SHIFT
    } rd_state_e;

    typedef struct packed {
        logic        load;
        logic [31:0] count;
    } tmr_cmd_t;

    typedef struct packed {
        logic arm;
        logic step;
    } sclk_cmd_t;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        int unsigned q;
        q = (num + den - 1) / den;
        return (q == 0) ? 1 : q;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/adc_reader_timer.sv
module adc_reader_timer #(
    parameter int unsigned CNT_W = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [31:0] count,
    output logic        expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(count - 32'd1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);

    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (rst)
        load |-> (count != 32'd0)); // R3

endmodule

// File: rtl/adc_reader_sclk.sv
module adc_reader_sclk
    import adc_reader_pkg::*;
#(
    parameter logic IDLE_LVL = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  sclk_cmd_t cmd,
    output logic      sclk,
    output logic      sample,
    output logic      last_half
);

    localparam int unsigned EW = $clog2(HALF_PERIODS + 1);
    localparam int unsigned BW = $clog2(RES_W + 1);

    logic          sclk_q;
    logic          fell_q;
    logic [EW-1:0] edges_q;
    logic [BW-1:0] bits_q;

    // A bit is taken on a rising level change once a falling change has moved the data.
    assign sample    = cmd.step && !sclk_q && fell_q && (bits_q < BW'(RES_W));
    assign last_half = (edges_q == EW'(HALF_PERIODS));
    assign sclk      = sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= IDLE_LVL;
            fell_q  <= 1'b0;
            edges_q <= '0;
            bits_q  <= '0;
        end else begin
            if (cmd.arm || cmd.step) begin
                sclk_q <= ~sclk_q;
            end
            if (cmd.arm) begin
                edges_q <= EW'(1);
                bits_q  <= BW'(1);
                fell_q  <= sclk_q;
            end else if (cmd.step) begin
                edges_q <= edges_q + EW'(1);
                if (sclk_q) begin
                    fell_q <= 1'b1;
                end
                if (sample) begin
                    bits_q <= bits_q + BW'(1);
                end
            end
        end
    end

    AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (rst)
        edges_q <= EW'(HALF_PERIODS)); // R5

    AST_BITS_COMPLETE: assert property (@(posedge clk) disable iff (rst)
        last_half |-> (bits_q == BW'(RES_W))); // R6

    AST_IDLE_AT_END: assert property (@(posedge clk) disable iff (rst)
        last_half |-> (sclk_q == IDLE_LVL)); // R5

endmodule

// File: rtl/adc_reader_shift.sv
module adc_reader_shift #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word
);

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
        end else if (load) begin
            word <= {{(W-1){1'b0}}, din};
        end else if (shift_en) begin
            word <= {word[W-2:0], din};
        end
    end

    AST_LOAD_SHIFT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(load && shift_en)); // R6

endmodule

// File: rtl/adc_reader.sv
module adc_reader
    import adc_reader_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS      = 8000,
    parameter int unsigned START_MIN_PS       = 50000,
    parameter int unsigned CONV_MIN_PS        = 7500000,
    parameter int unsigned SCLK_MIN_PERIOD_PS = 200000,
    parameter logic        SCLK_IDLE          = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             chan,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] result,
    output logic             conv_start,
    output logic             sclk,
    input  logic             din
);

    localparam int unsigned START_CYC = ceil_div(START_MIN_PS, CLK_PERIOD_PS);
    localparam int unsigned CONV_CYC  = ceil_div(CONV_MIN_PS, CLK_PERIOD_PS);
    localparam int unsigned HALF_CYC  = ceil_div(SCLK_MIN_PERIOD_PS, 2 * CLK_PERIOD_PS);
    localparam int unsigned CNT_W     = $clog2(max3(START_CYC, CONV_CYC, HALF_CYC) + 1);

    rd_state_e        state_q;
    logic             extra_q;
    logic             busy_q;
    logic             done_q;
    logic             cnvst_q;
    logic [RES_W-1:0] result_q;

    tmr_cmd_t         tmr;
    logic             tmr_exp;
    sclk_cmd_t        sc;
    logic             sample;
    logic             last_half;
    logic [RES_W-1:0] shift_word;

    // Timer and serial clock commands follow the current phase.
    always_comb begin
        tmr = '0;
        sc  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    tmr.load  = 1'b1;
                    tmr.count = 32'(START_CYC);
                end
            end
            ST_START_HI: begin
                if (tmr_exp) begin
                    tmr.load  = 1'b1;
                    tmr.count = extra_q ? 32'(START_CYC) : 32'(CONV_CYC);
                end
            end
            ST_START_LO: begin
                if (tmr_exp) begin
                    tmr.load  = 1'b1;
                    tmr.count = 32'(START_CYC);
                end
            end
            ST_CONVERT: begin
                if (tmr_exp) begin
                    tmr.load  = 1'b1;
                    tmr.count = 32'(HALF_CYC);
                    sc.arm    = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (tmr_exp && !last_half) begin
                    tmr.load  = 1'b1;
                    tmr.count = 32'(HALF_CYC);
                    sc.step   = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            extra_q  <= 1'b0;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            cnvst_q  <= 1'b0;
            result_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req) begin
                        state_q <= ST_START_HI;
                        cnvst_q <= 1'b1;
                        busy_q  <= 1'b1;
                        extra_q <= chan;
                    end
                end
                ST_START_HI: begin
                    if (tmr_exp) begin
                        cnvst_q <= 1'b0;
                        state_q <= extra_q ? ST_START_LO : ST_CONVERT;
                    end
                end
                ST_START_LO: begin
                    if (tmr_exp) begin
                        cnvst_q <= 1'b1;
                        extra_q <= 1'b0;
                        state_q <= ST_START_HI;
                    end
                end
                ST_CONVERT: begin
                    if (tmr_exp) begin
                        state_q <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tmr_exp && last_half) begin
                        state_q  <= ST_IDLE;
                        busy_q   <= 1'b0;
                        done_q   <= 1'b1;
                        result_q <= shift_word;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    adc_reader_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr.load),
        .count   (tmr.count),
        .expired (tmr_exp)
    );

    adc_reader_sclk #(
        .IDLE_LVL (SCLK_IDLE)
    ) u_sclk (
        .clk       (clk),
        .rst       (rst),
        .cmd       (sc),
        .sclk      (sclk),
        .sample    (sample),
        .last_half (last_half)
    );

    adc_reader_shift #(
        .W (RES_W)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (sc.arm),
        .shift_en (sample),
        .din      (din),
        .word     (shift_word)
    );

    assign busy       = busy_q;
    assign done       = done_q;
    assign result     = result_q;
    assign conv_start = cnvst_q;

    // Independent phase-length counters used only by the checks below.
    logic [31:0] conv_len_q;
    logic [31:0] hi_len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_len_q <= '0;
            hi_len_q   <= '0;
        end else begin
            conv_len_q <= (state_q == ST_CONVERT)  ? conv_len_q + 32'd1 : 32'd0;
            hi_len_q   <= (state_q == ST_START_HI) ? hi_len_q + 32'd1   : 32'd0;
        end
    end

    AST_CONV_WAIT: assert property (@(posedge clk) disable iff (rst)
        sc.arm |-> (conv_len_q == 32'(CONV_CYC - 1))); // R4

    AST_START_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_START_HI && tmr_exp) |-> (hi_len_q == 32'(START_CYC - 1))); // R3

    AST_NO_SCLK_IN_START: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> (sclk == SCLK_IDLE)); // R4

    AST_SCLK_IDLE_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sclk == SCLK_IDLE)); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R7

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!busy && req) |=> busy); // R10

    AST_RESULT_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> done); // R7

endmodule

// File: tb/adc_reader_tb.sv
module adc_reader_devmodel #(
    parameter int DEV_CONV = 900
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       cnvst,
    input  logic       sclk,
    input  logic [7:0] val0,
    input  logic [7:0] val1,
    output logic       dout,
    output int         n_pulse,
    output int         min_hi,
    output int         min_lo,
    output int         conv_gap,
    output int         n_edges,
    output int         min_half
);
    logic       cnvst_p, sclk_p, armed, sel, fell_once;
    int         conv_cnt, idx, run_c, run_s, since_fall;
    logic [7:0] cur;

    assign cur = sel ? val1 : val0;

    always @(posedge clk) begin
        if (rst || clr) begin
            cnvst_p <= cnvst; sclk_p <= sclk; armed <= 1'b0; sel <= 1'b0;
            fell_once <= 1'b0; conv_cnt <= 0; idx <= -1; run_c <= 1; run_s <= 1;
            since_fall <= 0; n_pulse <= 0; min_hi <= 1000000; min_lo <= 1000000;
            conv_gap <= 0; n_edges <= 0; min_half <= 1000000;
            if (rst) dout <= 1'b0;
        end else begin
            cnvst_p <= cnvst;
            sclk_p  <= sclk;
            if (cnvst != cnvst_p) begin
                run_c <= 1;
                if (cnvst_p) min_hi <= (run_c < min_hi) ? run_c : min_hi;
                else if (n_pulse > 0) min_lo <= (run_c < min_lo) ? run_c : min_lo;
            end else begin
                run_c <= run_c + 1;
            end
            if (fell_once && n_edges == 0) since_fall <= since_fall + 1;
            if (armed) conv_cnt <= conv_cnt + 1;
            if (armed && conv_cnt == DEV_CONV) begin
                dout  <= cur[7];
                idx   <= 7;
                armed <= 1'b0;
            end
            if (cnvst && !cnvst_p) begin
                n_pulse <= n_pulse + 1;
                armed   <= 1'b0;
            end
            if (!cnvst && cnvst_p) begin
                armed      <= 1'b1;
                conv_cnt   <= 1;
                since_fall <= 1;
                fell_once  <= 1'b1;
                dout       <= 1'b0;
                idx        <= -1;
                sel        <= (n_pulse >= 2);
            end
            if (sclk != sclk_p) begin
                n_edges <= n_edges + 1;
                if (n_edges == 0) conv_gap <= since_fall;
                else min_half <= (run_s < min_half) ? run_s : min_half;
                run_s <= 1;
            end else begin
                run_s <= run_s + 1;
            end
            if (!sclk && sclk_p && idx >= 0) begin
                dout <= (idx > 0) ? cur[idx-1] : 1'b0;
                idx  <= idx - 1;
            end
        end
    end
endmodule

module adc_reader_tb;
    localparam int EXP_START = 7;    // ceil(50000 / 8000)
    localparam int EXP_CONV  = 938;  // ceil(7500000 / 8000)
    localparam int EXP_HALF  = 13;   // ceil(200000 / 16000)
    localparam logic [8:0] VEC [8] = '{9'h000, 9'h1FF, 9'h0A5, 9'h15A,
                                       9'h080, 9'h101, 9'h1C3, 9'h07E};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0;
    logic chan = 1'b0;
    logic clr = 1'b0;
    logic [7:0] v0 = '0;
    logic [7:0] v1 = '0;

    logic busy0, done0, cs0, sclk0, din0;
    logic busy1, done1, cs1, sclk1, din1;
    logic [7:0] result0, result1;
    int n_pulse0, min_hi0, min_lo0, conv_gap0, n_edges0, min_half0;
    int n_pulse1, min_hi1, min_lo1, conv_gap1, n_edges1, min_half1;

    int checks = 0;
    int fails = 0;
    int dcnt0 = 0;
    int dcnt1 = 0;
    logic [7:0] res0 = '0;
    logic [7:0] res1 = '0;
    logic bdone0 = 1'b0;

    always #4 clk = ~clk;

    adc_reader u_dut (
        .clk(clk), .rst(rst), .req(req), .chan(chan), .busy(busy0), .done(done0),
        .result(result0), .conv_start(cs0), .sclk(sclk0), .din(din0));

    adc_reader #(.SCLK_IDLE(1'b1)) u_dut1 (
        .clk(clk), .rst(rst), .req(req), .chan(chan), .busy(busy1), .done(done1),
        .result(result1), .conv_start(cs1), .sclk(sclk1), .din(din1));

    adc_reader_devmodel m0 (
        .clk(clk), .rst(rst), .clr(clr), .cnvst(cs0), .sclk(sclk0), .val0(v0), .val1(v1),
        .dout(din0), .n_pulse(n_pulse0), .min_hi(min_hi0), .min_lo(min_lo0),
        .conv_gap(conv_gap0), .n_edges(n_edges0), .min_half(min_half0));

    adc_reader_devmodel m1 (
        .clk(clk), .rst(rst), .clr(clr), .cnvst(cs1), .sclk(sclk1), .val0(v0), .val1(v1),
        .dout(din1), .n_pulse(n_pulse1), .min_hi(min_hi1), .min_lo(min_lo1),
        .conv_gap(conv_gap1), .n_edges(n_edges1), .min_half(min_half1));

    always @(posedge clk) begin
        #2;
        if (done0) begin dcnt0 = dcnt0 + 1; res0 = result0; bdone0 = busy0; end
        if (done1) begin dcnt1 = dcnt1 + 1; res1 = result1; end
    end

    task automatic chk_eq(input string rq, input string what, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic chk_ge(input string rq, input string what, input int act, input int lim);
        checks = checks + 1;
        if (act < lim) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %0d expected at least %0d", rq, what, act, lim);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic do_read(input logic c, input logic [7:0] a0, input logic [7:0] a1,
                           input bit noise);
        int cyc;
        @(negedge clk);
        v0 = a0; v1 = a1; clr = 1'b1; dcnt0 = 0; dcnt1 = 0;
        @(negedge clk);
        clr = 1'b0; req = 1'b1; chan = c;
        @(negedge clk);
        req = 1'b0;
        chk_eq("R7", "busy after accept", int'(busy0), 1);
        cyc = 0;
        while (dcnt0 == 0 && cyc < 4000) begin
            @(negedge clk);
            cyc = cyc + 1;
            if (noise && (cyc == 40 || cyc == 1000)) begin req = 1'b1; chan = ~c; end
            else begin req = 1'b0; chan = c; end
        end
        req = 1'b0;
        if (cyc >= 4000) chk_eq("R7", "read timeout", 0, 1);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails = fails + 1;
        checks = checks + 1;
        $display("FAIL R7 watchdog expired: actual hung expected finished");
        report();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_eq("R1", "busy at reset", int'(busy0), 0);
        chk_eq("R1", "done at reset", int'(done0), 0);
        chk_eq("R1", "conv_start at reset", int'(cs0), 0);
        chk_eq("R1", "result at reset", int'(result0), 0);
        chk_eq("R1", "sclk idle low", int'(sclk0), 0);
        chk_eq("R1", "sclk idle high", int'(sclk1), 1);

        foreach (VEC[i]) begin
            logic c;
            logic [7:0] d;
            c = VEC[i][8];
            d = VEC[i][7:0];
            do_read(c, c ? ~d : d, c ? d : ~d, 1'b0);
            chk_eq("R6", "result low idle", int'(res0), int'(d));
            chk_eq("R9", "result high idle", int'(res1), int'(d));
            chk_eq("R2", "start pulses", n_pulse0, int'(c) + 1);
            chk_ge("R3", "start high width", min_hi0, EXP_START);
            if (c) chk_ge("R3", "start low gap", min_lo0, EXP_START);
            chk_ge("R4", "conversion wait", conv_gap0, EXP_CONV);
            chk_eq("R5", "sclk level changes", n_edges0, 16);
            chk_eq("R9", "sclk level changes high idle", n_edges1, 16);
            chk_ge("R5", "sclk half period", min_half0, EXP_HALF);
            chk_eq("R5", "sclk back idle", int'(sclk0), 0);
            chk_eq("R9", "sclk back idle high", int'(sclk1), 1);
            chk_eq("R7", "done count", dcnt0, 1);
            chk_eq("R7", "busy in done cycle", int'(bdone0), 0);
        end

        // R8: requests for the other channel while busy change nothing
        do_read(1'b0, 8'h3C, 8'hC3, 1'b1);
        chk_eq("R8", "result keeps channel 0", int'(res0), 8'h3C);
        chk_eq("R8", "no extra start pulse", n_pulse0, 1);
        repeat (50) @(negedge clk);
        chk_eq("R8", "single done", dcnt0, 1);
        chk_eq("R8", "idle afterwards", int'(busy0), 0);

        // R10: request held through the done cycle starts a new read
        @(negedge clk);
        v0 = 8'h11; v1 = 8'hE7; clr = 1'b1; dcnt0 = 0; dcnt1 = 0;
        @(negedge clk);
        clr = 1'b0; req = 1'b1; chan = 1'b0;
        @(negedge clk);
        chan = 1'b1;
        begin
            int cyc = 0;
            while (dcnt0 == 0 && cyc < 4000) begin @(negedge clk); cyc = cyc + 1; end
        end
        chk_eq("R10", "first result", int'(res0), 8'h11);
        @(negedge clk);
        chk_eq("R10", "busy after done with req", int'(busy0), 1);
        chk_eq("R10", "done cleared", int'(done0), 0);
        req = 1'b0;
        begin
            int cyc = 0;
            while (dcnt0 < 2 && cyc < 4000) begin @(negedge clk); cyc = cyc + 1; end
        end
        chk_eq("R10", "second done", dcnt0, 2);
        chk_eq("R10", "second result channel 1", int'(res0), 8'hE7);
        report();
    end
endmodule